// File: doc/BRIEF.md
# UART Register File with Interrupt Logic

This block is the host-facing register bank of a byte-oriented serial port with the programming model of the classic PC serial controller. A host reaches eight byte-wide registers through an address, a data byte and separate read and write strobes. Read data comes back registered one cycle after the read strobe. The opposite side is a byte-level character channel. Transmitted bytes leave as a one-cycle strobe with data. Received bytes come in with an availability flag and are acknowledged by a pop pulse. Bit timing, baud generation and FIFO storage are outside the block. It keeps the divisor, decodes the programmed line format onto plain outputs, and works out interrupt identification and line and modem status.

The host address is divided by the parameter `STRIDE` before decoding, so the block fits buses that place registers 1, 2, 4 or more bytes apart. A latch-access bit in line control switches offsets 0 and 1 between the data/enable pair and the two divisor bytes. A loopback mode in modem control sends written bytes back into the receive path instead of out on the channel.

Top module: `uart_regfile`

## Requirements
- R1: After reset the divisor is 12, line control reads 0x03 (8 data bits, no parity, 1 stop bit, latch-access bit 0), the enable register reads 0, the identification register reads 0x01, `tx_valid_o` and `irq_o` are 0.
- R2: The register index is `addr_i / STRIDE`. An index of 8 or more neither writes any register nor reads anything but 0, and an unaligned address selects the index its quotient gives.
- R3: With line-control bit 7 set, offset 0 reads and writes divisor bits [7:0] and offset 1 reads and writes bits [15:8], `divisor_o` follows them, and no byte is sent. With bit 7 clear, offset 1 is the enable register again.
- R4: `data_bits_o` = 5 + line-control [1:0]. `stop_halves_o` (stop length in half bits) is 2 when bit 2 is clear, 3 when bit 2 is set with 5 data bits, and 4 otherwise. `parity_o` from bits [5:3]: 0→0 none, 1→1 odd, 3→2 even, 5→3 forced zero, 7→4 forced one, any other code→7 undefined. `break_o` is bit 6.
- R5: A data write at offset 0 (latch-access 0, loopback off) raises `tx_valid_o` with `tx_data_o` equal to the byte for exactly the next cycle, and sets the tx-pending flag.
- R6: With modem-control bit 4 set, a data write sends nothing on the channel. The byte is held as received data, so line-status bit 0 reads 1 and the next data read returns that byte and clears it. The byte takes precedence over a channel byte.
- R7: Writing the enable register (bit 0 rx, bit 1 tx) so that bit 1 goes from 0 to 1 sets the tx-pending flag.
- R8: The identification register reads bit 0 = no interrupt pending, bit 1 = tx pending, bit 2 = received data available, bits [5:3] = 0, bits [7:6] = FIFO-control bits [2:1]. An interrupt is pending when (enable bit 1 and tx pending) or (enable bit 0 and received data available).
- R9: `irq_o` is 1 exactly when an interrupt is pending and modem-control bit 3 is set.
- R10: Line status reads bits 6 and 5 as 1, bit 0 as received-data availability, and the remaining bits as last written. Modem status reads bits 7, 5 and 4 as 1 and the others as last written.
- R11: A data read returns the received byte and, when that byte comes from the channel, pulses `rx_pop_o` in the same cycle. With `in_use_i` low it returns 0, gives no pop, and received data counts as unavailable.
- R12: Line control, modem control and the spare register at offset 7 read back as written. A write to offset 2 stores FIFO control and does not change the value read at offset 2, apart from bits [7:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Host byte address, divided by STRIDE |
| wdata_i | input | 8 | Host write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request |
| in_use_i | input | 1 | Channel present; low makes receive data unavailable |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| rx_data_i | input | 8 | Received byte from the channel |
| rx_avail_i | input | 1 | Channel holds a received byte |
| rx_pop_o | output | 1 | Channel byte consumed this cycle |
| divisor_o | output | 16 | Current baud divisor |
| data_bits_o | output | 4 | Decoded character length |
| stop_halves_o | output | 3 | Stop length in half bits |
| parity_o | output | 3 | Parity mode code |
| break_o | output | 1 | Break requested |

## Verification
The two functions that can fall in the same cycle are the interrupt condition set by the host and the arrival of a channel byte. The bench raises `rx_avail_i` at the same edge that an enable write turns on both interrupt sources. It then expects the identification register to show the rx and tx bits together with no-pending clear. A second collision comes from loopback: a loopback byte and a channel byte are both waiting. The first data read must return the loopback byte without a pop, and the following read must pop the channel byte.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int NUM_REGS = 8;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IEN  = 3'd1;
    localparam logic [2:0] OFS_IDF  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LST  = 3'd5;
    localparam logic [2:0] OFS_MST  = 3'd6;
    localparam logic [2:0] OFS_SPR  = 3'd7;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_ZERO  = 3'd3,
        PAR_ONE   = 3'd4,
        PAR_UNDEF = 3'd7
    } parity_e;

    typedef struct packed {
        logic [7:0]  lcr;
        logic [7:0]  mcr;
        logic [7:0]  ien;
        logic [7:0]  fcr;
        logic [7:0]  lst;
        logic [7:0]  mst;
        logic [7:0]  spr;
        logic [15:0] divisor;
        logic        tx_pend;
        logic        lb_valid;
        logic [7:0]  lb_data;
        logic        tx_valid;
        logic [7:0]  tx_data;
        logic [7:0]  rdata;
    } rf_state_t;

endpackage

// File: rtl/uart_fmt_dec.sv
module uart_fmt_dec
    import uart_rf_pkg::*;
(
    input  logic [6:0] lcr_i,
    output logic [3:0] data_bits_o,
    output logic [2:0] stop_halves_o,
    output logic [2:0] parity_o,
    output logic       break_o
);
    parity_e par;

    always_comb begin
        data_bits_o = 4'd5 + {2'b00, lcr_i[1:0]};
        if (!lcr_i[2])
            stop_halves_o = 3'd2;
        else if (lcr_i[1:0] == 2'b00)
            stop_halves_o = 3'd3;
        else
            stop_halves_o = 3'd4;
        case (lcr_i[5:3])
            3'd0:    par = PAR_NONE;
            3'd1:    par = PAR_ODD;
            3'd3:    par = PAR_EVEN;
            3'd5:    par = PAR_ZERO;
            3'd7:    par = PAR_ONE;
            default: par = PAR_UNDEF;
        endcase
        parity_o = par;
        break_o  = lcr_i[6];
    end
endmodule

// File: rtl/uart_irq_eval.sv
module uart_irq_eval (
    input  logic [1:0] ien_i,
    input  logic       tx_pend_i,
    input  logic       rx_rdy_i,
    input  logic       gate_i,
    output logic       nopend_o,
    output logic       irq_o
);
    logic pending;

    always_comb begin
        pending  = (ien_i[1] && tx_pend_i) || (ien_i[0] && rx_rdy_i);
        nopend_o = !pending;
        irq_o    = pending && gate_i;
    end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          STRIDE      = 1,
    parameter logic [15:0] RESET_DIV   = 16'd12,
    parameter bit          FIFO_REPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o,
    input  logic              in_use_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_avail_i,
    output logic              rx_pop_o,
    output logic [15:0]       divisor_o,
    output logic [3:0]        data_bits_o,
    output logic [2:0]        stop_halves_o,
    output logic [2:0]        parity_o,
    output logic              break_o
);
    localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);
    localparam logic [ADDR_W-1:0] NREG_V   = ADDR_W'(NUM_REGS);
    localparam rf_state_t RST_STATE = '{
        lcr: 8'h03, mcr: 8'h00, ien: 8'h00, fcr: 8'h00, lst: 8'h00,
        mst: 8'h00, spr: 8'h00, divisor: RESET_DIV, tx_pend: 1'b0,
        lb_valid: 1'b0, lb_data: 8'h00, tx_valid: 1'b0, tx_data: 8'h00,
        rdata: 8'h00
    };

    rf_state_t   q, d;
    logic [ADDR_W-1:0] idx_full;
    logic [2:0]  sel;
    logic        in_range, dlab, loopback, rx_rdy, nopend;
    logic        wr_data, rd_data;
    logic [7:0]  iir_view, lst_view, fifo_bits;

    always_comb begin
        idx_full  = addr_i / STRIDE_V;
        in_range  = idx_full < NREG_V;
        sel       = idx_full[2:0];
        dlab      = q.lcr[7];
        loopback  = q.mcr[4];
        rx_rdy    = in_use_i && (q.lb_valid || rx_avail_i);
        wr_data   = wr_en_i && in_range && sel == OFS_DATA && !dlab;
        rd_data   = rd_en_i && in_range && sel == OFS_DATA && !dlab;
        rx_pop_o  = rd_data && in_use_i && !q.lb_valid && rx_avail_i;
        fifo_bits = FIFO_REPORT ? {q.fcr[2:1], 6'b0} : 8'h00;
        iir_view  = fifo_bits | {5'b0, rx_rdy, q.tx_pend, nopend};
        lst_view  = {q.lst[7], 2'b11, q.lst[4:1], rx_rdy};
    end

    uart_irq_eval u_irq (
        .ien_i     (q.ien[1:0]),
        .tx_pend_i (q.tx_pend),
        .rx_rdy_i  (rx_rdy),
        .gate_i    (q.mcr[3]),
        .nopend_o  (nopend),
        .irq_o     (irq_o)
    );

    uart_fmt_dec u_fmt (
        .lcr_i         (q.lcr[6:0]),
        .data_bits_o   (data_bits_o),
        .stop_halves_o (stop_halves_o),
        .parity_o      (parity_o),
        .break_o       (break_o)
    );

    always_comb begin
        d = q;
        d.tx_valid = 1'b0;
        // read side: capture data and consume loopback byte
        if (rd_en_i) begin
            d.rdata = 8'h00;
            if (in_range) begin
                case (sel)
                    OFS_DATA: begin
                        if (dlab)
                            d.rdata = q.divisor[7:0];
                        else if (in_use_i) begin
                            d.rdata = q.lb_valid ? q.lb_data : rx_data_i;
                            d.lb_valid = 1'b0;
                        end
                    end
                    OFS_IEN: d.rdata = dlab ? q.divisor[15:8] : q.ien;
                    OFS_IDF: d.rdata = iir_view;
                    OFS_LCR: d.rdata = q.lcr;
                    OFS_MCR: d.rdata = q.mcr;
                    OFS_LST: d.rdata = lst_view;
                    OFS_MST: d.rdata = q.mst | 8'hB0;
                    default: d.rdata = q.spr;
                endcase
            end
        end
        // write side
        if (wr_en_i && in_range) begin
            case (sel)
                OFS_DATA: begin
                    if (dlab)
                        d.divisor[7:0] = wdata_i;
                    else begin
                        d.tx_pend = 1'b1;
                        if (loopback) begin
                            d.lb_valid = 1'b1;
                            d.lb_data  = wdata_i;
                        end else begin
                            d.tx_valid = 1'b1;
                            d.tx_data  = wdata_i;
                        end
                    end
                end
                OFS_IEN: begin
                    if (dlab)
                        d.divisor[15:8] = wdata_i;
                    else begin
                        if (!q.ien[1] && wdata_i[1])
                            d.tx_pend = 1'b1;
                        d.ien = wdata_i;
                    end
                end
                OFS_IDF: d.fcr = wdata_i;
                OFS_LCR: d.lcr = wdata_i;
                OFS_MCR: d.mcr = wdata_i;
                OFS_LST: d.lst = wdata_i;
                OFS_MST: d.mst = wdata_i;
                default: d.spr = wdata_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_STATE;
        else        q <= d;
    end

    assign rdata_o    = q.rdata;
    assign tx_data_o  = q.tx_data;
    assign tx_valid_o = q.tx_valid;
    assign divisor_o  = q.divisor;

    AST_DLAB_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && in_range && sel == OFS_DATA && dlab) |=> !tx_valid_o); // R3
    AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !loopback) |=> (tx_valid_o && tx_data_o == $past(wdata_i))); // R5
    AST_LOOP_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && loopback) |=> (!tx_valid_o && q.lb_valid)); // R6
    AST_TXEN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && in_range && sel == OFS_IEN && !dlab && !q.ien[1] && wdata_i[1])
        |=> q.tx_pend); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (q.mcr[3] && !nopend)); // R9
    AST_LST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && in_range && sel == OFS_LST) |=> rdata_o[6:5] == 2'b11); // R10
    AST_NO_POP_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !in_use_i |-> !rx_pop_o); // R11
endmodule

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
    localparam int ADDR_W = 8;
    localparam int STRIDE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata;
    logic irq, in_use = 1'b1;
    logic [7:0] tx_data;
    logic tx_valid;
    logic [7:0] rx_data = '0;
    logic rx_avail = 1'b0;
    logic rx_pop;
    logic [15:0] divisor;
    logic [3:0] data_bits;
    logic [2:0] stop_halves, parity;
    logic brk;

    int n_run = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic rd_fire = 1'b0;

    always #10 clk = ~clk;

    uart_regfile #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .irq_o(irq),
        .in_use_i(in_use), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
        .rx_data_i(rx_data), .rx_avail_i(rx_avail), .rx_pop_o(rx_pop),
        .divisor_o(divisor), .data_bits_o(data_bits),
        .stop_halves_o(stop_halves), .parity_o(parity), .break_o(brk)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compares registered read data against the scoreboard
    always @(posedge clk) rd_fire <= rd_en;
    always @(negedge clk) begin
        if (rd_fire && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {8'h00, rdata}, {8'h00, e});
        end
    end

    task automatic wr_at(logic [ADDR_W-1:0] a, logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(int idx, logic [7:0] v);
        wr_at(ADDR_W'(idx * STRIDE), v);
    endtask

    task automatic rd_at(logic [ADDR_W-1:0] a, logic [7:0] e, string tag,
                         logic exp_pop);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        #1 check({tag, " pop"}, {15'd0, rx_pop}, {15'd0, exp_pop});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd(int idx, logic [7:0] e, string tag);
        rd_at(ADDR_W'(idx * STRIDE), e, tag, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 divisor", divisor, 16'd12);
        check("R1 bits", {12'd0, data_bits}, 16'd8);
        check("R1 stop", {13'd0, stop_halves}, 16'd2);
        check("R1 parity", {13'd0, parity}, 16'd0);
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
        rd(3, 8'h03, "R1 lcr");
        rd(2, 8'h01, "R1 iir");
        rd(1, 8'h00, "R1 ien");
        rd(5, 8'h60, "R10 lsr reset");
        rd(6, 8'hB0, "R10 msr reset");

        // R3 divisor overlay
        wr(3, 8'h83);
        rd(0, 8'h0C, "R3 div lo");
        rd(1, 8'h00, "R3 div hi");
        wr(0, 8'h34);
        check("R3 no tx", {15'd0, tx_valid}, 16'd0);
        wr(1, 8'h12);
        check("R3 divisor", divisor, 16'h1234);
        rd(0, 8'h34, "R3 lo back");
        rd(1, 8'h12, "R3 hi back");
        wr(3, 8'h03);
        rd(1, 8'h00, "R3 ien restored");
        rd(2, 8'h01, "R3 no tx pend");

        // R4 format decode
        wr(3, 8'h04);
        check("R4 5b", {12'd0, data_bits}, 16'd5);
        check("R4 1.5 stop", {13'd0, stop_halves}, 16'd3);
        wr(3, 8'h0D);
        check("R4 6b", {12'd0, data_bits}, 16'd6);
        check("R4 2 stop", {13'd0, stop_halves}, 16'd4);
        check("R4 odd", {13'd0, parity}, 16'd1);
        wr(3, 8'h5B);
        check("R4 even", {13'd0, parity}, 16'd2);
        check("R4 break", {15'd0, brk}, 16'd1);
        check("R4 1 stop", {13'd0, stop_halves}, 16'd2);
        wr(3, 8'h2A);
        check("R4 7b", {12'd0, data_bits}, 16'd7);
        check("R4 zero", {13'd0, parity}, 16'd3);
        wr(3, 8'h3B);
        check("R4 one", {13'd0, parity}, 16'd4);
        wr(3, 8'h13);
        check("R4 undef", {13'd0, parity}, 16'd7);
        wr(3, 8'h03);
        check("R4 no break", {15'd0, brk}, 16'd0);

        // R5 transmit strobe
        wr(0, 8'h5A);
        check("R5 tx_valid", {15'd0, tx_valid}, 16'd1);
        check("R5 tx_data", {8'd0, tx_data}, 16'h005A);
        @(negedge clk);
        check("R5 single pulse", {15'd0, tx_valid}, 16'd0);
        rd(2, 8'h03, "R5 tx pend");

        // R7 / R8 / R9 interrupts
        do_reset();
        wr(1, 8'h02);
        rd(2, 8'h02, "R7 rise sets pend");
        check("R9 ungated", {15'd0, irq}, 16'd0);
        wr(4, 8'h08);
        check("R9 gated on", {15'd0, irq}, 16'd1);
        wr(1, 8'h00);
        check("R9 disabled", {15'd0, irq}, 16'd0);
        rd(2, 8'h03, "R8 no pending");
        wr(2, 8'h06);
        rd(2, 8'hC3, "R8 fifo bits 11");
        wr(2, 8'h02);
        rd(2, 8'h43, "R8 fifo bits 01");
        wr(2, 8'h00);
        rx_data = 8'h77; rx_avail = 1'b1;
        rd(2, 8'h07, "R8 rx flag");
        wr(1, 8'h01);
        rd(2, 8'h06, "R8 rx pending");
        check("R9 rx irq", {15'd0, irq}, 16'd1);
        rd(5, 8'h61, "R10 rx ready");

        // R11 data read pops the channel
        rd_at(ADDR_W'(0), 8'h77, "R11 read byte", 1'b1);
        rx_avail = 1'b0;
        rd(2, 8'h03, "R11 after pop");
        check("R11 irq cleared", {15'd0, irq}, 16'd0);
        in_use = 1'b0; rx_avail = 1'b1;
        rd(5, 8'h60, "R11 unused lsr");
        rd_at(ADDR_W'(0), 8'h00, "R11 unused read", 1'b0);
        in_use = 1'b1; rx_avail = 1'b0;

        // same-cycle rx arrival and enable write
        do_reset();
        @(negedge clk);
        addr = ADDR_W'(1 * STRIDE); wdata = 8'h03; wr_en = 1'b1;
        rx_data = 8'h3C; rx_avail = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2, 8'h06, "R8 both sources");

        // R6 loopback, precedence over channel byte
        wr(4, 8'h10);
        wr(0, 8'hA5);
        check("R6 no tx", {15'd0, tx_valid}, 16'd0);
        rd_at(ADDR_W'(0), 8'hA5, "R6 loop byte", 1'b0);
        rd_at(ADDR_W'(0), 8'h3C, "R6 then channel", 1'b1);
        rx_avail = 1'b0;
        rd(5, 8'h60, "R6 lsr empty");
        wr(0, 8'h42);
        rd(5, 8'h61, "R6 lsr ready");
        rd_at(ADDR_W'(0), 8'h42, "R6 read back", 1'b0);
        rd(5, 8'h60, "R6 cleared");

        // R10 status registers
        wr(5, 8'h1E);
        rd(5, 8'h7E, "R10 lsr stored");
        wr(6, 8'h0F);
        rd(6, 8'hBF, "R10 msr forced");

        // R12 plain registers
        wr(4, 8'h1F);
        rd(4, 8'h1F, "R12 mcr");
        wr(7, 8'h99);
        rd(7, 8'h99, "R12 spare");
        wr(3, 8'h45);
        rd(3, 8'h45, "R12 lcr");
        wr(3, 8'h03);

        // R2 address stride and range
        wr_at(ADDR_W'(8 * STRIDE), 8'h55);
        rd_at(ADDR_W'(8 * STRIDE), 8'h00, "R2 out of range", 1'b0);
        rd_at(ADDR_W'(7 * STRIDE + 1), 8'h99, "R2 unaligned", 1'b0);
        rd(7, 8'h99, "R2 spare intact");

        finish_run();
    end
endmodule